// File: doc/BRIEF.md
# Modular Elliptic-Curve Step Sequencer

This block is a coprocessor datapath that carries out one elliptic-curve point step over a prime field. It does this by running a fixed list of modular operations. Every operation is an addition, a subtraction or a multiplication modulo a common value N. Each one reads two source registers and writes one destination register. The host places the current point (x, y), two candidate addend points P and Q, the curve coefficient a, a precomputed inverse and the modulus N on the inputs. It chooses a path and pulses `start`. The inverse is computed outside the block.

At the start pulse the block copies the operands into a small register file, so the host may change the inputs while the block runs. A micro-sequence held in the package then drives one shared modular ALU, one operation per micro-step. Additions and subtractions take one ALU cycle. Multiplication is interleaved shift-and-add, MSB first, taking one multiplier bit per cycle. It keeps a running remainder below N, so no double-width product is ever formed. The point-add paths (P or Q) take eight micro-steps and the doubling path takes eleven. When the last step writes back, the result y is presented on `y_out` and `done` pulses for one cycle.

The controller has four states:
- `ST_IDLE` waits for `start`.
- `ST_ISSUE` launches the current micro-step on the ALU.
- `ST_WAIT` waits for the ALU result and writes it back. It then goes either to `ST_ISSUE` for the next step, or to `ST_FINISH` after the last step.
- `ST_FINISH` raises `done` and returns to `ST_IDLE`.

Top module: `ec_step_engine`

## Requirements
- R1: After reset, `busy` and `done` are low and `y_out` is zero.
- R2: With `path_sel` = 0 the block returns y_out = lam*(x - tx) - y mod N, where lam = (p_y - y)*lam_inv, tx = lam^2 - (x + p_x), and every operation is modulo N.
- R3: With `path_sel` = 1 the same formula as R2 is computed with q_x and q_y in place of p_x and p_y.
- R4: With `path_sel[1]` = 1 (values 2 and 3) the doubling formula is used. It computes lam = (x^2 + x^2 + x^2 + curve_a)*lam_inv, tx = lam^2 - x - x and y_out = lam*(x - tx) - y, all modulo N.
- R5: Every modular add and subtract wraps correctly at the edges of the range, including operands equal to N-1, operands of zero, and a modulus with its top bit set. Every result lies in 0..N-1.
- R6: Every multiply returns the full 2W-bit product reduced modulo N, including for operands of N-1.
- R7: The modulus is sampled at each accepted start, so a new N applies from the next run on.
- R8: While `busy` is high, `start` is ignored. Input changes after the accepted start have no effect on the result.
- R9: `busy` rises in the cycle after an accepted start. `done` is high for exactly one cycle, in the last busy cycle.
- R10: `y_out` keeps its value from the `done` cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; accepted only while idle |
| path_sel | input | 2 | 0: add P, 1: add Q, 2 or 3: doubling |
| mod_n | input | W | Modulus N |
| x_in | input | W | Current point x, reduced |
| y_in | input | W | Current point y, reduced |
| p_x | input | W | Addend point P, x |
| p_y | input | W | Addend point P, y |
| q_x | input | W | Addend point Q, x |
| q_y | input | W | Addend point Q, y |
| curve_a | input | W | Curve coefficient used when doubling |
| lam_inv | input | W | Precomputed inverse for the slope |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when `y_out` is valid |
| y_out | output | W | Resulting y coordinate |

## Verification
The bench aims at the wrap corners of the modular operations. These include a sum of two N-1 values, a subtraction from zero, and a modulus of the form 2^128 - 59, where a sum overflows W bits. A design that dropped the carry bit or forgot the correcting add or subtract would return a value of N or more, or a wrong residue. It runs every path, including both doubling codes, on the same operands. A swapped P/Q select or a wrong micro-step would then show up as a mismatched y. It also pulses `start` and changes every input in the middle of a run, and it changes N between runs. A design that did not latch operands, accepted a restart, or used a stale modulus would return a result built from the wrong values.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

    localparam int IDX_W    = 4;
    localparam int STEP_W   = 4;
    localparam int LOAD_CNT = 6;
    localparam int REG_CNT  = 10;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2
    } alu_op_e;

    // register file slots: the first LOAD_CNT are filled at start
    localparam logic [IDX_W-1:0] RG_X   = 4'd0;
    localparam logic [IDX_W-1:0] RG_Y   = 4'd1;
    localparam logic [IDX_W-1:0] RG_BX  = 4'd2;
    localparam logic [IDX_W-1:0] RG_BY  = 4'd3;
    localparam logic [IDX_W-1:0] RG_A   = 4'd4;
    localparam logic [IDX_W-1:0] RG_INV = 4'd5;
    localparam logic [IDX_W-1:0] RG_LAM = 4'd6;
    localparam logic [IDX_W-1:0] RG_T   = 4'd7;
    localparam logic [IDX_W-1:0] RG_T2  = 4'd8;
    localparam logic [IDX_W-1:0] RG_TX  = 4'd9;

    typedef struct packed {
        alu_op_e          op;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] sa;
        logic [IDX_W-1:0] sb;
        logic             last;
    } uop_t;

    function automatic uop_t mk_uop(input alu_op_e op, input logic [IDX_W-1:0] d,
                                    input logic [IDX_W-1:0] a, input logic [IDX_W-1:0] b,
                                    input logic lst);
        uop_t u;
        u.op   = op;
        u.dst  = d;
        u.sa   = a;
        u.sb   = b;
        u.last = lst;
        return u;
    endfunction

    // micro-sequence: dbl selects the doubling list, otherwise the point-add list
    function automatic uop_t uop_fetch(input logic dbl, input logic [STEP_W-1:0] step);
        uop_t u;
        u = mk_uop(OP_SUB, RG_T, RG_T, RG_Y, 1'b1);
        if (dbl) begin
            unique case (step)
                4'd0:    u = mk_uop(OP_MUL, RG_T,   RG_X,   RG_X,   1'b0);
                4'd1:    u = mk_uop(OP_ADD, RG_T2,  RG_T,   RG_T,   1'b0);
                4'd2:    u = mk_uop(OP_ADD, RG_T2,  RG_T2,  RG_T,   1'b0);
                4'd3:    u = mk_uop(OP_ADD, RG_LAM, RG_T2,  RG_A,   1'b0);
                4'd4:    u = mk_uop(OP_MUL, RG_LAM, RG_LAM, RG_INV, 1'b0);
                4'd5:    u = mk_uop(OP_MUL, RG_T,   RG_LAM, RG_LAM, 1'b0);
                4'd6:    u = mk_uop(OP_SUB, RG_T,   RG_T,   RG_X,   1'b0);
                4'd7:    u = mk_uop(OP_SUB, RG_TX,  RG_T,   RG_X,   1'b0);
                4'd8:    u = mk_uop(OP_SUB, RG_T,   RG_X,   RG_TX,  1'b0);
                4'd9:    u = mk_uop(OP_MUL, RG_T,   RG_LAM, RG_T,   1'b0);
                default: u = mk_uop(OP_SUB, RG_T,   RG_T,   RG_Y,   1'b1);
            endcase
        end else begin
            unique case (step)
                4'd0:    u = mk_uop(OP_SUB, RG_LAM, RG_BY,  RG_Y,   1'b0);
                4'd1:    u = mk_uop(OP_MUL, RG_LAM, RG_LAM, RG_INV, 1'b0);
                4'd2:    u = mk_uop(OP_ADD, RG_T,   RG_X,   RG_BX,  1'b0);
                4'd3:    u = mk_uop(OP_MUL, RG_T2,  RG_LAM, RG_LAM, 1'b0);
                4'd4:    u = mk_uop(OP_SUB, RG_TX,  RG_T2,  RG_T,   1'b0);
                4'd5:    u = mk_uop(OP_SUB, RG_T,   RG_X,   RG_TX,  1'b0);
                4'd6:    u = mk_uop(OP_MUL, RG_T,   RG_LAM, RG_T,   1'b0);
                default: u = mk_uop(OP_SUB, RG_T,   RG_T,   RG_Y,   1'b1);
            endcase
        end
        return u;
    endfunction

endpackage

// File: rtl/ecs_regfile.sv
module ecs_regfile #(
    parameter int W        = 128,
    parameter int DEPTH    = ecs_pkg::REG_CNT,
    parameter int LOAD_N   = ecs_pkg::LOAD_CNT,
    parameter int IDX_W    = ecs_pkg::IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [LOAD_N*W-1:0] load_bus,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [W-1:0]        wr_data,
    input  logic [IDX_W-1:0]    rd_a_idx,
    input  logic [IDX_W-1:0]    rd_b_idx,
    output logic [W-1:0]        rd_a,
    output logic [W-1:0]        rd_b
);

    logic [W-1:0] regs [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        if (g < LOAD_N) begin : g_loadable
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs[g] <= '0;
                end else if (load_en) begin
                    regs[g] <= load_bus[g*W +: W];
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    regs[g] <= wr_data;
                end
            end
        end else begin : g_temp
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs[g] <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    regs[g] <= wr_data;
                end
            end
        end
    end

    always_comb begin
        rd_a = '0;
        rd_b = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_a_idx == IDX_W'(i)) rd_a = regs[i];
            if (rd_b_idx == IDX_W'(i)) rd_b = regs[i];
        end
    end

endmodule

// File: rtl/ecs_serial_mul.sv
module ecs_serial_mul #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] n,
    output logic         rdy,
    output logic [W-1:0] prod
);

    localparam int CW = $clog2(W);

    typedef enum logic {M_IDLE, M_RUN} mstate_e;

    mstate_e       st_q;
    logic [W-1:0]  acc_q, mc_q, mp_q, n_q;
    logic [CW-1:0] cnt_q;
    logic          rdy_q;
    logic [W:0]    dbl_w, red1_w, sum_w, red2_w;

    // one multiplier bit per cycle: acc = 2*acc (+ mc) kept below n
    always_comb begin
        dbl_w  = {acc_q, 1'b0};
        red1_w = (dbl_w >= {1'b0, n_q}) ? (dbl_w - {1'b0, n_q}) : dbl_w;
        sum_w  = red1_w + (mp_q[W-1] ? {1'b0, mc_q} : '0);
        red2_w = (sum_w >= {1'b0, n_q}) ? (sum_w - {1'b0, n_q}) : sum_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= M_IDLE;
            acc_q <= '0;
            mc_q  <= '0;
            mp_q  <= '0;
            n_q   <= '0;
            cnt_q <= '0;
            rdy_q <= 1'b0;
        end else begin
            rdy_q <= 1'b0;
            unique case (st_q)
                M_IDLE: begin
                    if (go) begin
                        acc_q <= '0;
                        mc_q  <= a;
                        mp_q  <= b;
                        n_q   <= n;
                        cnt_q <= CW'(W-1);
                        st_q  <= M_RUN;
                    end
                end
                M_RUN: begin
                    acc_q <= red2_w[W-1:0];
                    mp_q  <= {mp_q[W-2:0], 1'b0};
                    if (cnt_q == '0) begin
                        rdy_q <= 1'b1;
                        st_q  <= M_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: st_q <= M_IDLE;
            endcase
        end
    end

    assign rdy  = rdy_q;
    assign prod = acc_q;

endmodule

// File: rtl/ecs_modalu.sv
module ecs_modalu #(
    parameter int W = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  ecs_pkg::alu_op_e op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [W-1:0]    n,
    output logic            rdy,
    output logic [W-1:0]    res
);

    import ecs_pkg::*;

    logic [W:0]   sum_w, sumr_w;
    logic [W-1:0] dif_w, as_res_w;
    logic [W-1:0] as_q, mul_p;
    logic         as_rdy_q, mul_rdy, mul_go;

    always_comb begin
        sum_w  = {1'b0, a} + {1'b0, b};
        sumr_w = (sum_w >= {1'b0, n}) ? (sum_w - {1'b0, n}) : sum_w;
        dif_w  = (a >= b) ? (a - b) : (a - b + n);
        as_res_w = (op == OP_SUB) ? dif_w : sumr_w[W-1:0];
    end

    assign mul_go = go && (op == OP_MUL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_q     <= '0;
            as_rdy_q <= 1'b0;
        end else begin
            as_rdy_q <= go && (op != OP_MUL);
            if (go && (op != OP_MUL)) as_q <= as_res_w;
        end
    end

    ecs_serial_mul #(.W(W)) u_mul (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (mul_go),
        .a    (a),
        .b    (b),
        .n    (n),
        .rdy  (mul_rdy),
        .prod (mul_p)
    );

    assign rdy = as_rdy_q | mul_rdy;
    assign res = mul_rdy ? mul_p : as_q;

endmodule

// File: rtl/ec_step_engine.sv
module ec_step_engine #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   path_sel,
    input  logic [W-1:0] mod_n,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic [W-1:0] p_x,
    input  logic [W-1:0] p_y,
    input  logic [W-1:0] q_x,
    input  logic [W-1:0] q_y,
    input  logic [W-1:0] curve_a,
    input  logic [W-1:0] lam_inv,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] y_out
);

    import ecs_pkg::*;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FINISH} state_e;

    state_e              st_q, st_d;
    logic [STEP_W-1:0]   step_q;
    logic                dbl_q;
    logic [W-1:0]        n_q, y_q;
    uop_t                uop;
    logic                accept, alu_go, alu_rdy, wr_en;
    logic [W-1:0]        opa, opb, alu_res;
    logic [LOAD_CNT*W-1:0] load_bus;

    assign accept = start && (st_q == ST_IDLE);
    assign uop    = uop_fetch(dbl_q, step_q);
    assign wr_en  = (st_q == ST_WAIT) && alu_rdy;

    // operands in slot order: x, y, base x, base y, a, inverse
    assign load_bus = {lam_inv, curve_a,
                       (path_sel == 2'd1) ? q_y : p_y,
                       (path_sel == 2'd1) ? q_x : p_x,
                       y_in, x_in};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = ST_ISSUE;
            ST_ISSUE:  st_d = ST_WAIT;
            ST_WAIT:   if (alu_rdy) st_d = uop.last ? ST_FINISH : ST_ISSUE;
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        busy   = 1'b1;
        done   = 1'b0;
        alu_go = 1'b0;
        unique case (st_q)
            ST_IDLE:   busy   = 1'b0;
            ST_ISSUE:  alu_go = 1'b1;
            ST_WAIT:   ;
            ST_FINISH: done   = 1'b1;
            default:   busy   = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
            dbl_q  <= 1'b0;
            n_q    <= '0;
            y_q    <= '0;
        end else begin
            if (accept) begin
                step_q <= '0;
                dbl_q  <= path_sel[1];
                n_q    <= mod_n;
            end else if (wr_en && !uop.last) begin
                step_q <= step_q + 1'b1;
            end
            if (wr_en && uop.last) y_q <= alu_res;
        end
    end

    assign y_out = y_q;

    ecs_regfile #(.W(W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (accept),
        .load_bus(load_bus),
        .wr_en   (wr_en),
        .wr_idx  (uop.dst),
        .wr_data (alu_res),
        .rd_a_idx(uop.sa),
        .rd_b_idx(uop.sb),
        .rd_a    (opa),
        .rd_b    (opb)
    );

    ecs_modalu #(.W(W)) u_alu (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (alu_go),
        .op   (uop.op),
        .a    (opa),
        .b    (opb),
        .n    (n_q),
        .rdy  (alu_rdy),
        .res  (alu_res)
    );

endmodule

// File: rtl/ec_step_engine_chk.sv
module ec_step_engine_chk #(
    parameter int W = 128
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] y_out,
    input logic [W-1:0] n_q
);

    // R9: done lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done only appears inside a busy run
    a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R9: an accepted start makes the block busy next cycle
    a_r9_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8: a run cannot be cut short; busy holds until the done cycle
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R10: result unchanged while idle with no start
    a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(y_out));

    // R5: returned value is reduced below the modulus of the run
    a_r5_result_reduced: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (y_out < n_q));

endmodule

bind ec_step_engine ec_step_engine_chk #(.W(W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .busy (busy),
    .done (done),
    .y_out(y_out),
    .n_q  (n_q)
);

// File: tb/ec_step_engine_bench.sv
`timescale 1ns/1ps
module ec_step_engine_bench;

    localparam int W     = 128;
    localparam int LIMIT = 4000;

    typedef struct packed {
        logic [1:0]   path;
        logic [W-1:0] n, x, y, px, py, qx, qy, a, inv;
    } vec_t;

    localparam logic [W-1:0] BN = 128'h00001BD579792B380B5B521E6D9FB599;
    localparam logic [W-1:0] SN = 128'd97;
    localparam logic [W-1:0] HN = 128'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFC5;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, BN, 128'h6A09E667F3BCC908B2FB1366, 128'hBB67AE8584CAA73B2A54FF53,
          128'h3C6EF372FE94F82BA54FF53A, 128'h510E527FADE682D19B05688C,
          128'h1F83D9ABFB41BD6B5BE0CD19, 128'h9B05688C2B3E6C1F1F83D9AB,
          128'h3, 128'h0D8A5B2C91E4F7A6305B1C2D3E},
        '{2'd1, BN, 128'h6A09E667F3BCC908B2FB1366, 128'hBB67AE8584CAA73B2A54FF53,
          128'h3C6EF372FE94F82BA54FF53A, 128'h510E527FADE682D19B05688C,
          128'h1F83D9ABFB41BD6B5BE0CD19, 128'h9B05688C2B3E6C1F1F83D9AB,
          128'h3, 128'h0D8A5B2C91E4F7A6305B1C2D3E},
        '{2'd2, BN, 128'h6A09E667F3BCC908B2FB1366, 128'hBB67AE8584CAA73B2A54FF53,
          128'h3C6EF372FE94F82BA54FF53A, 128'h510E527FADE682D19B05688C,
          128'h1F83D9ABFB41BD6B5BE0CD19, 128'h9B05688C2B3E6C1F1F83D9AB,
          128'h3, 128'h0D8A5B2C91E4F7A6305B1C2D3E},
        '{2'd3, BN, 128'h6A09E667F3BCC908B2FB1366, 128'hBB67AE8584CAA73B2A54FF53,
          128'h3C6EF372FE94F82BA54FF53A, 128'h510E527FADE682D19B05688C,
          128'h1F83D9ABFB41BD6B5BE0CD19, 128'h9B05688C2B3E6C1F1F83D9AB,
          128'h3, 128'h0D8A5B2C91E4F7A6305B1C2D3E},
        '{2'd0, SN, 128'd96, 128'd96, 128'd96, 128'd0, 128'd5, 128'd5, 128'd96, 128'd96},
        '{2'd2, SN, 128'd0, 128'd0, 128'd1, 128'd1, 128'd1, 128'd1, 128'd96, 128'd1},
        '{2'd0, HN, HN-128'd1, HN-128'd2, HN-128'd1, 128'd1, 128'd7, 128'd9,
          128'd0, HN-128'd1},
        '{2'd2, HN, HN-128'd1, 128'd1, 128'd0, 128'd0, 128'd0, 128'd0,
          HN-128'd1, HN-128'd2}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   path_sel = '0;
    logic [W-1:0] mod_n = '0, x_in = '0, y_in = '0, p_x = '0, p_y = '0;
    logic [W-1:0] q_x = '0, q_y = '0, curve_a = '0, lam_inv = '0;
    logic         busy, done;
    logic [W-1:0] y_out;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ec_step_engine #(.W(W)) u_ec_step_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .path_sel(path_sel),
        .mod_n(mod_n), .x_in(x_in), .y_in(y_in), .p_x(p_x), .p_y(p_y),
        .q_x(q_x), .q_y(q_y), .curve_a(curve_a), .lam_inv(lam_inv),
        .busy(busy), .done(done), .y_out(y_out)
    );

    // reference arithmetic, written from the requirements
    function automatic logic [W-1:0] madd(input logic [W-1:0] a, b, n);
        logic [W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, n}) s = s - {1'b0, n};
        return s[W-1:0];
    endfunction

    function automatic logic [W-1:0] msub(input logic [W-1:0] a, b, n);
        logic [W:0] s;
        s = {1'b0, a} + {1'b0, n} - {1'b0, b};
        if (s >= {1'b0, n}) s = s - {1'b0, n};
        return s[W-1:0];
    endfunction

    function automatic logic [W-1:0] mmul(input logic [W-1:0] a, b, n);
        logic [2*W-1:0] p;
        p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        p = p % {{W{1'b0}}, n};
        return p[W-1:0];
    endfunction

    function automatic logic [W-1:0] ref_step(input vec_t v);
        logic [W-1:0] lam, t, t2, tx, bx, by;
        if (v.path[1]) begin
            t   = mmul(v.x, v.x, v.n);
            t2  = madd(t, t, v.n);
            t2  = madd(t2, t, v.n);
            lam = madd(t2, v.a, v.n);
            lam = mmul(lam, v.inv, v.n);
            t   = mmul(lam, lam, v.n);
            t   = msub(t, v.x, v.n);
            tx  = msub(t, v.x, v.n);
        end else begin
            bx  = (v.path == 2'd1) ? v.qx : v.px;
            by  = (v.path == 2'd1) ? v.qy : v.py;
            lam = msub(by, v.y, v.n);
            lam = mmul(lam, v.inv, v.n);
            t   = madd(v.x, bx, v.n);
            t2  = mmul(lam, lam, v.n);
            tx  = msub(t2, t, v.n);
        end
        t = msub(v.x, tx, v.n);
        t = mmul(lam, t, v.n);
        return msub(t, v.y, v.n);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        path_sel = v.path;
        mod_n = v.n; x_in = v.x; y_in = v.y; p_x = v.px; p_y = v.py;
        q_x = v.qx; q_y = v.qy; curve_a = v.a; lam_inv = v.inv;
    endtask

    // waits at negedges until done; returns 0 on timeout
    task automatic wait_done(output bit ok);
        int cyc = 0;
        while (!done && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        ok = done;
        if (!ok) begin
            bad++;
            total++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, LIMIT);
        end
    endtask

    function automatic string req_of(input logic [1:0] p);
        if (p[1])      return "R4";
        if (p == 2'd1) return "R3";
        return "R2";
    endfunction

    initial begin
        bit ok;
        logic [W-1:0] exp_y, held;
        vec_t v2;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", W'(busy), '0);
        chk(done == 1'b0, "R1 done", W'(done), '0);
        chk(y_out == '0,  "R1 y_out", y_out, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 R3 R4, plus R5 R6 wrap corners and R7 modulus changes
        for (int i = 0; i < NVEC; i++) begin
            exp_y = ref_step(VEC[i]);
            drive(VEC[i]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R9 busy after start", W'(busy), W'(1));
            wait_done(ok);
            if (ok) begin
                chk(y_out == exp_y, $sformatf("%s R5 R6 R7 vector %0d", req_of(VEC[i].path), i),
                    y_out, exp_y);
                @(negedge clk);
                chk(done == 1'b0, "R9 done one cycle", W'(done), '0);
                chk(busy == 1'b0, "R9 idle after done", W'(busy), '0);
            end
        end

        // R8: start and input changes during a run are ignored
        exp_y = ref_step(VEC[0]);
        drive(VEC[0]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        v2 = VEC[3];
        v2.x = 128'h55;
        v2.n = SN;
        drive(v2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        if (ok) chk(y_out == exp_y, "R8 restart ignored", y_out, exp_y);

        // R10: held after done, inputs moving, no start
        held = y_out;
        drive(VEC[5]);
        repeat (12) @(negedge clk);
        chk(y_out == held, "R10 held", y_out, held);
        chk(done == 1'b0, "R10 no extra done", W'(done), '0);

        // R7: same operands under a different modulus
        v2 = VEC[4];
        v2.n = 128'd101;
        exp_y = ref_step(v2);
        drive(v2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        if (ok) chk(y_out == exp_y, "R7 reload modulus", y_out, exp_y);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(150000 * 4);
        bad++;
        total++;
        $display("FAIL global watchdog R9 actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule